// File: doc/BRIEF.md
# Dual-Mode Converter Output Interface

This block sits between the digital back end of a 10-bit sampling converter and the device pins. Each rising edge of the sample clock accepts one converter word and one out-of-range flag. The block models the converter's fixed pipeline latency with a register delay line, so each word reaches the pins exactly 14 sample clocks after it was accepted. The out-of-range flag travels through the same delay line as its word.

A single mode input selects one of two pin formats. In the parallel format, all ten data pins carry the word for the whole clock period. In the double-data-rate format, the word is split into bit pairs across five lanes. Each lane sends its even bit while the clock is high and its odd bit while the clock is low. A data-valid clock goes out with the data in both formats: it is centred in the data eye for the parallel format and aligned to the data edges for the double-data-rate format.

A mode change costs one sample period with quiet outputs. Reset clears the delay line and silences the outputs.

Top module: `adc_out_if`

## Requirements
- R1: With the mode input at 0 (parallel), pin `data_o[i]` carries bit i of the delayed word (bit 9 most significant, bit 0 least) for the full clock period.
- R2: With the mode input at 1 (double data rate), lane k is `data_o[k]` for k = 0..4. Lane k carries word bit 2k while `clk` is high and word bit 2k+1 while `clk` is low. Pins `data_o[9:5]` are 0.
- R3: A word driven on `sample_i` during sample cycle c appears on the pins during cycle c+14, in both formats.
- R4: `ovr_o` carries the flag accepted with the word shown on the pins in the same cycle (14 cycles of delay) and holds it for the whole period.
- R5: The data-valid clock `dv_clk_o` is the inverse of `clk` in parallel format (it rises mid-period) and equals `clk` in double-data-rate format.
- R6: The mode value sampled at a rising edge sets the pin format for the clock period that starts at that edge.
- R7: In the single clock period after an edge that samples a changed mode value, `data_o` and `ovr_o` are 0 and `dv_clk_o` is low. From the next period on, the outputs follow the new format.
- R8: While `rst_n` is low, `data_o` and `ovr_o` are 0 and `dv_clk_o` is low. Reset empties the delay line, so the first 14 periods after release show word 0 and flag 0, with the data-valid clock running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; the rising edge accepts a sample |
| rst_n | input | 1 | Asynchronous reset, active low |
| ddr_mode_i | input | 1 | Format select: 0 parallel, 1 double data rate |
| sample_i | input | 10 | Converter word |
| ovr_i | input | 1 | Out-of-range flag for `sample_i` |
| data_o | output | 10 | Data pins (lanes on bits 4..0 in double-data-rate format) |
| ovr_o | output | 1 | Delayed out-of-range flag |
| dv_clk_o | output | 1 | Data-valid clock for the receiver |

## Verification
The assertions check these rules on every cycle:
- quiet outputs during reset and during the blank period after a mode change;
- idle upper pins in double-data-rate format;
- the phase of the data-valid clock relative to `clk` in each format;
- the blank period starting after a mode change.

Only the bench's scenarios can show the rest, because it compares the pins against a history of the driven stimulus. That covers the 14-cycle latency, the bit-to-lane pairing in both clock phases, the alignment of the flag with its word, and the zero words that flush out after reset.

// File: rtl/adc_oif_pkg.sv
package adc_oif_pkg;

  // converter word width and modelled pipeline depth
  parameter int unsigned WORD_W  = 10;
  parameter int unsigned PIPE_LAT = 14;
  localparam int unsigned LANE_N = WORD_W / 2;

  typedef enum logic {
    FMT_PARALLEL = 1'b0,
    FMT_DDR      = 1'b1
  } pin_fmt_e;

  // bit carried by lane k in the given clock phase (1 = high phase)
  function automatic logic lane_bit(input logic [WORD_W-1:0] word,
                                    input int unsigned k,
                                    input logic hi_phase);
    return hi_phase ? word[2*k] : word[2*k+1];
  endfunction

  // data-valid clock derived from the sample clock for each format
  function automatic logic dv_level(input pin_fmt_e fmt, input logic clk_lvl);
    return (fmt == FMT_DDR) ? clk_lvl : ~clk_lvl;
  endfunction

endpackage

// File: rtl/adc_oif_delay.sv
module adc_oif_delay #(
  parameter int unsigned WIDTH = 11,
  parameter int unsigned DEPTH = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/adc_oif_mode.sv
module adc_oif_mode
  import adc_oif_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ddr_mode_i,
  output pin_fmt_e fmt_o,
  output logic     blank_o
);

  pin_fmt_e fmt_q;
  logic     blank_q;
  pin_fmt_e fmt_next;

  assign fmt_next = ddr_mode_i ? FMT_DDR : FMT_PARALLEL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q   <= FMT_PARALLEL;
      blank_q <= 1'b0;
    end else begin
      fmt_q   <= fmt_next;
      blank_q <= (fmt_next != fmt_q);
    end
  end

  assign fmt_o   = fmt_q;
  assign blank_o = blank_q;

endmodule

// File: rtl/adc_oif_fmt.sv
module adc_oif_fmt
  import adc_oif_pkg::*;
#(
  parameter int unsigned DW = 10
) (
  input  logic          clk,
  input  logic          quiet,
  input  pin_fmt_e      fmt,
  input  logic [DW-1:0] word,
  input  logic          ovr,
  output logic [DW-1:0] pins,
  output logic          ovr_pin,
  output logic          dv_pin
);

  localparam int unsigned LANES = DW / 2;

  for (genvar k = 0; k < DW; k++) begin : g_pin
    if (k < LANES) begin : g_lane
      always_comb begin
        if (quiet)                pins[k] = 1'b0;
        else if (fmt == FMT_DDR)  pins[k] = lane_bit(word, k, clk);
        else                      pins[k] = word[k];
      end
    end else begin : g_upper
      always_comb begin
        if (quiet || fmt == FMT_DDR) pins[k] = 1'b0;
        else                         pins[k] = word[k];
      end
    end
  end

  assign ovr_pin = quiet ? 1'b0 : ovr;
  assign dv_pin  = quiet ? 1'b0 : dv_level(fmt, clk);

endmodule

// File: rtl/adc_out_if.sv
module adc_out_if
  import adc_oif_pkg::*;
#(
  parameter int unsigned DATA_W  = adc_oif_pkg::WORD_W,
  parameter int unsigned LATENCY = adc_oif_pkg::PIPE_LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ddr_mode_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              ovr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ovr_o,
  output logic              dv_clk_o
);

  localparam int unsigned PIPE_W = DATA_W + 1;

  logic [PIPE_W-1:0] pipe_in;
  logic [PIPE_W-1:0] pipe_out;
  pin_fmt_e          fmt_w;
  logic              blank_w;
  logic              quiet_w;

  assign pipe_in = {ovr_i, sample_i};

  adc_oif_delay #(.WIDTH(PIPE_W), .DEPTH(LATENCY)) u_delay (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pipe_in),
    .dout (pipe_out)
  );

  adc_oif_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .ddr_mode_i(ddr_mode_i),
    .fmt_o     (fmt_w),
    .blank_o   (blank_w)
  );

  assign quiet_w = !rst_n || blank_w;

  adc_oif_fmt #(.DW(DATA_W)) u_fmt (
    .clk    (clk),
    .quiet  (quiet_w),
    .fmt    (fmt_w),
    .word   (pipe_out[DATA_W-1:0]),
    .ovr    (pipe_out[DATA_W]),
    .pins   (data_o),
    .ovr_pin(ovr_o),
    .dv_pin (dv_clk_o)
  );

endmodule

// File: rtl/adc_out_if_checker.sv
module adc_out_if_checker #(
  parameter int unsigned DW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ddr_mode_i,
  input logic          fmt_ddr,
  input logic          blank,
  input logic [DW-1:0] data_o,
  input logic          ovr_o,
  input logic          dv_clk_o
);

  localparam int unsigned LANES = DW / 2;

  // negedge sampling observes the high half of the period
  a_r8_reset_quiet: assert property (@(negedge clk)
    !rst_n |-> (data_o == '0 && !ovr_o && !dv_clk_o));

  a_r7_blank_quiet: assert property (@(negedge clk) disable iff (!rst_n)
    blank |-> (data_o == '0 && !ovr_o && !dv_clk_o));

  a_r7_blank_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(ddr_mode_i)) |=> blank);

  a_r2_upper_idle: assert property (@(negedge clk) disable iff (!rst_n)
    fmt_ddr |-> (data_o[DW-1:LANES] == '0));

  a_r5_dv_ddr_high: assert property (@(negedge clk) disable iff (!rst_n)
    (fmt_ddr && !blank) |-> dv_clk_o);

  a_r5_dv_par_low: assert property (@(negedge clk) disable iff (!rst_n)
    (!fmt_ddr && !blank) |-> !dv_clk_o);

endmodule

bind adc_out_if adc_out_if_checker #(.DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ddr_mode_i(ddr_mode_i),
  .fmt_ddr   (fmt_w == adc_oif_pkg::FMT_DDR),
  .blank     (blank_w),
  .data_o    (data_o),
  .ovr_o     (ovr_o),
  .dv_clk_o  (dv_clk_o)
);

// File: tb/adc_out_if_test.sv
module adc_out_if_test;

  localparam int DW  = 10;
  localparam int LAT = 14;
  localparam int OFS = 32;
  localparam int HN  = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ddr_mode_i = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic          ovr_i = 1'b0;
  logic [DW-1:0] data_o;
  logic          ovr_o;
  logic          dv_clk_o;

  int checks = 0;
  int errors = 0;
  int cyc = -1;
  bit done = 0;

  logic [DW-1:0] h_word [HN];
  logic          h_ovr  [HN];
  logic          h_mode [HN];

  always #10 clk = ~clk;

  adc_out_if uut (
    .clk(clk), .rst_n(rst_n), .ddr_mode_i(ddr_mode_i),
    .sample_i(sample_i), .ovr_i(ovr_i),
    .data_o(data_o), .ovr_o(ovr_o), .dv_clk_o(dv_clk_o)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp_v);
    end
  endtask

  // expected pins for a word, format and phase
  function automatic logic [DW-1:0] exp_pins(input logic [DW-1:0] w,
                                             input logic ddr, input logic hi);
    logic [DW-1:0] r;
    r = '0;
    if (!ddr) return w;
    for (int k = 0; k < DW/2; k++) r[k] = hi ? w[2*k] : w[2*k+1];
    return r;
  endfunction

  // drive one sample cycle and check the pins in both halves
  task automatic step(input logic [DW-1:0] w, input logic o, input logic m);
    logic          mode_now, blank, exp_ovr;
    logic [DW-1:0] ew;
    string         tag;
    @(posedge clk);
    #2;
    cyc++;
    sample_i = w; ovr_i = o; ddr_mode_i = m;
    h_word[cyc+OFS] = w; h_ovr[cyc+OFS] = o; h_mode[cyc+OFS] = m;
    mode_now = h_mode[cyc-1+OFS];
    blank    = (h_mode[cyc-1+OFS] != h_mode[cyc-2+OFS]);
    ew       = h_word[cyc-LAT+OFS];
    exp_ovr  = h_ovr[cyc-LAT+OFS];
    tag = blank ? "R7" : (mode_now ? "R2/R3" : "R1/R3");
    #3;
    chk(tag, data_o, blank ? 0 : exp_pins(ew, mode_now, 1'b1));
    chk(blank ? "R7" : "R5", dv_clk_o, blank ? 0 : mode_now);
    chk(blank ? "R7" : "R4", ovr_o, blank ? 0 : exp_ovr);
    #10;
    chk(tag, data_o, blank ? 0 : exp_pins(ew, mode_now, 1'b0));
    chk(blank ? "R7" : "R5", dv_clk_o, blank ? 0 : !mode_now);
    chk(blank ? "R7" : "R4", ovr_o, blank ? 0 : exp_ovr);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic        m;
    seed = 32'h5eed_0a1c;
    void'($urandom(seed));
    for (int i = 0; i < HN; i++) begin
      h_word[i] = '0; h_ovr[i] = 1'b0; h_mode[i] = 1'b0;
    end
    // R8: during reset, drive busy inputs; outputs stay quiet
    sample_i = 10'h3ff; ovr_i = 1'b1;
    repeat (3) begin
      @(posedge clk); #5;
      chk("R8", data_o, 0); chk("R8", dv_clk_o, 0); chk("R8", ovr_o, 0);
      #10;
      chk("R8", data_o, 0); chk("R8", dv_clk_o, 0);
    end
    sample_i = '0; ovr_i = 1'b0;
    @(posedge clk); #2; rst_n = 1'b1;
    // R8/R3: first 14 cycles after release show the flushed zero word
    step(10'h3ff, 1'b1, 1'b0);
    step(10'h2aa, 1'b0, 1'b0);
    step(10'h155, 1'b1, 1'b0);
    for (int i = 0; i < 40; i++) step(10'($urandom), 1'($urandom), 1'b0);
    // R6/R7: change to double data rate, then directed lane patterns (R2)
    step(10'h3ff, 1'b0, 1'b1);
    step(10'h2aa, 1'b1, 1'b1);
    step(10'h155, 1'b0, 1'b1);
    step(10'h001, 1'b0, 1'b1);
    step(10'h200, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) step(10'($urandom), 1'($urandom), 1'b1);
    // back-to-back mode toggles: blank in consecutive periods
    step(10'h0f0, 1'b0, 1'b0);
    step(10'h30f, 1'b1, 1'b1);
    step(10'h111, 1'b0, 1'b0);
    // random stream with occasional mode changes
    m = 1'b0;
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 23) == 0) m = ~m;
      step(10'($urandom), 1'($urandom), m);
    end
    for (int i = 0; i < 20; i++) step(10'($urandom), 1'($urandom), m);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule